// File: doc/BRIEF.md
# Serial-Programmed Dual-Loop Power-Down Controller

This block is the digital front end of a two-loop frequency synthesizer. A host writes control words over a three-wire serial port: a shift clock, a data line and a latch strobe. Bits enter a shift register most significant bit first. When the latch strobe rises, the two least significant bits of the word pick the latch that takes it. Code 00 selects the loop 0 reference word, which holds the 14-bit reference divide count and loop 0's charge-pump three-state and power-down bits. Code 01 selects the loop 0 swallow/program divider word. Code 10 selects the loop 1 control word. Code 11 is discarded.

Each loop has its own power-down sequencer. If the loop's three-state bit is clear when a power-down request is latched, entry is deferred. The charge pump is parked in three-state at once, and the loop goes fully down at the next phase-comparison strobe for that loop. If the three-state bit was already set by an earlier word, the loop goes down directly on the latch event. A powered-down loop forces its dividers to their load state and debiases its input stage. The shared reference oscillator is turned off only while both power-down bits are set. The serial port and all latches keep working in every power state. Latching a 0 into a loop's power-down bit returns that loop to normal operation at once.

Top module: `pdc_top`

## Requirements
- R1: Serial data is shifted in MSB first, one bit per rising edge of `ser_clk_i`. No latch or power state changes unless `ser_le_i` rises.
- R2: A word with control code 00 (bits [1:0]) loads bits [15:2] into `ref_cnt_o` and leaves the divider outputs unchanged.
- R3: A word with control code 01 loads bits [7:2] into `a_cnt_o` and bits [18:8] into `b_cnt_o`, and leaves `ref_cnt_o` and both loops' power states unchanged.
- R4: A word with control code 11 changes no output.
- R5: Loop 0 synchronous entry: bit 16 is three-state and bit 17 is power-down in a code 00 word. If a word sets bit 17 while the previously latched bit 16 is 0, `cp_tri_o[0]` goes high at once. `pd_o[0]` stays low until a `cmp_stb_i[0]` pulse, after which it is high.
- R6: Loop 0 asynchronous entry: if the previously latched three-state bit is 1, latching power-down = 1 raises `pd_o[0]` in the cycle after the latch event, with no strobe needed.
- R7: Loop 1 follows R5 and R6 using a code 10 word, with the same bit 16/17 positions, `cmp_stb_i[1]` and output index 1.
- R8: While a loop is down, its `pd_o`, `div_load_o`, `debias_o` and `cp_tri_o` bits are all high. While it is running, `pd_o`, `div_load_o` and `debias_o` are low and `cp_tri_o` equals its latched three-state bit.
- R9: `ref_osc_en_o` is low exactly when both loops' latched power-down bits are 1.
- R10: Divider and reference latches keep accepting words while either loop is waiting or down.
- R11: Latching power-down = 0 for a loop returns it to running in the cycle after the latch event, from either the waiting or the down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (synchronized internally) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Latch strobe; rising edge latches the word |
| cmp_stb_i | input | 2 | Per-loop one-cycle phase-comparison strobe |
| ref_cnt_o | output | 14 | Loop 0 reference divide count |
| a_cnt_o | output | 6 | Loop 0 swallow count |
| b_cnt_o | output | 11 | Loop 0 program count |
| pd_o | output | 2 | Per-loop powered-down flag |
| cp_tri_o | output | 2 | Per-loop charge-pump three-state enable |
| div_load_o | output | 2 | Per-loop divider load-state force |
| debias_o | output | 2 | Per-loop input-stage debias |
| ref_osc_en_o | output | 1 | Reference oscillator enable |

## Verification
The hardest state to reach from the ports is a loop held in its deferred-entry state while other words arrive. That includes new divider words, a rewrite of the three-state bit, or a clearing word that must cancel the pending power-down before any strobe. Directed sequences write a power-down request with three-state clear and then vary what comes next. A seeded random phase interleaves words of every control code with sparse per-loop strobes, so the bench's reference model sees many wait, strobe and clear orderings on both loops.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    PD_RUN  = 2'd0,
    PD_WAIT = 2'd1,
    PD_DOWN = 2'd2
  } pd_state_e;

  localparam logic [1:0] CODE_REF0 = 2'b00;
  localparam logic [1:0] CODE_DIV0 = 2'b01;
  localparam logic [1:0] CODE_CTL1 = 2'b10;
endpackage

// File: rtl/pdc_serial.sv
module pdc_serial #(
  parameter int WORD_W = 19,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [WORD_W-1:0] word_o,
  output logic              lat_o
);
  logic [SYNC_N-1:0] clk_s, dat_s, le_s;
  logic              clk_q, le_q;
  logic              shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_s <= '0;
      dat_s <= '0;
      le_s  <= '0;
    end else begin
      clk_s <= {clk_s[SYNC_N-2:0], ser_clk_i};
      dat_s <= {dat_s[SYNC_N-2:0], ser_dat_i};
      le_s  <= {le_s[SYNC_N-2:0], ser_le_i};
    end
  end

  assign shift_en = clk_s[SYNC_N-1] & ~clk_q;
  assign lat_o    = le_s[SYNC_N-1] & ~le_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= 1'b0;
      le_q   <= 1'b0;
      word_o <= '0;
    end else begin
      clk_q <= clk_s[SYNC_N-1];
      le_q  <= le_s[SYNC_N-1];
      if (shift_en) word_o <= {word_o[WORD_W-2:0], dat_s[SYNC_N-1]};
    end
  end

  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word_o));
endmodule

// File: rtl/pdc_loop.sv
module pdc_loop
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lat_i,
  input  logic tri_i,
  input  logic pd_i,
  input  logic cmp_stb_i,
  output logic pd_bit_o,
  output logic pd_o,
  output logic cp_tri_o,
  output logic div_load_o,
  output logic debias_o
);
  pd_state_e st_q;
  logic      tri_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PD_RUN;
      tri_q    <= 1'b0;
      pd_bit_o <= 1'b0;
    end else if (lat_i) begin
      tri_q    <= tri_i;
      pd_bit_o <= pd_i;
      if (!pd_i)              st_q <= PD_RUN;
      else if (st_q == PD_RUN) st_q <= tri_q ? PD_DOWN : PD_WAIT;
    end else if (st_q == PD_WAIT && cmp_stb_i) begin
      st_q <= PD_DOWN;
    end
  end

  assign pd_o       = (st_q == PD_DOWN);
  assign div_load_o = pd_o;
  assign debias_o   = pd_o;
  assign cp_tri_o   = tri_q | (st_q != PD_RUN);

  // R5
  sync_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PD_RUN && lat_i && pd_i && !tri_q) |=> (st_q == PD_WAIT));
  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PD_WAIT && !cmp_stb_i && !lat_i) |=> (st_q == PD_WAIT));
  // R6
  async_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PD_RUN && lat_i && pd_i && tri_q) |=> pd_o);
  // R11
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_i && !pd_i) |=> (!pd_o && st_q == PD_RUN));
endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter int REF_W  = 14,
  parameter int A_W    = 6,
  parameter int B_W    = 11,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_le_i,
  input  logic [1:0]       cmp_stb_i,
  output logic [REF_W-1:0] ref_cnt_o,
  output logic [A_W-1:0]   a_cnt_o,
  output logic [B_W-1:0]   b_cnt_o,
  output logic [1:0]       pd_o,
  output logic [1:0]       cp_tri_o,
  output logic [1:0]       div_load_o,
  output logic [1:0]       debias_o,
  output logic             ref_osc_en_o
);
  localparam int CTRL_W  = 2;
  localparam int WORD_W  = CTRL_W + A_W + B_W;
  localparam int REF_LSB = CTRL_W;
  localparam int TRI_BIT = REF_LSB + REF_W;
  localparam int PD_BIT  = TRI_BIT + 1;
  localparam int A_LSB   = CTRL_W;
  localparam int B_LSB   = A_LSB + A_W;

  logic [WORD_W-1:0] word;
  logic              lat;
  logic [CTRL_W-1:0] code;
  logic [1:0]        loop_lat;
  logic [1:0]        pd_bits;

  pdc_serial #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) ser_u (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i), .ser_le_i(ser_le_i),
    .word_o(word), .lat_o(lat)
  );

  assign code        = word[CTRL_W-1:0];
  assign loop_lat[0] = lat && (code == CODE_REF0);
  assign loop_lat[1] = lat && (code == CODE_CTL1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt_o <= '0;
      a_cnt_o   <= '0;
      b_cnt_o   <= '0;
    end else if (lat) begin
      if (code == CODE_REF0) ref_cnt_o <= word[REF_LSB +: REF_W];
      if (code == CODE_DIV0) begin
        a_cnt_o <= word[A_LSB +: A_W];
        b_cnt_o <= word[B_LSB +: B_W];
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_loop
    pdc_loop loop_u (
      .clk(clk), .rst(rst),
      .lat_i(loop_lat[g]),
      .tri_i(word[TRI_BIT]),
      .pd_i(word[PD_BIT]),
      .cmp_stb_i(cmp_stb_i[g]),
      .pd_bit_o(pd_bits[g]),
      .pd_o(pd_o[g]),
      .cp_tri_o(cp_tri_o[g]),
      .div_load_o(div_load_o[g]),
      .debias_o(debias_o[g])
    );
  end

  assign ref_osc_en_o = ~(&pd_bits);

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_lat[0] |=> $stable(ref_cnt_o));
  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(lat && code == CODE_DIV0) |=> ($stable(a_cnt_o) && $stable(b_cnt_o)));
  // R9
  osc_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_osc_en_o) |-> $past(lat));
endmodule

// File: tb/pdc_top_tb_top.sv
module pdc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [1:0]  cmp_stb = 2'b00;
  logic [13:0] ref_cnt;
  logic [5:0]  a_cnt;
  logic [10:0] b_cnt;
  logic [1:0]  pd, cp_tri, div_load, debias;
  logic        ref_osc_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [13:0] m_ref;
  logic [5:0]  m_a;
  logic [10:0] m_b;
  logic [1:0]  m_tri, m_pdb;
  int          m_st [2];

  always #2 clk = ~clk;

  pdc_top dut_i (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
    .cmp_stb_i(cmp_stb),
    .ref_cnt_o(ref_cnt), .a_cnt_o(a_cnt), .b_cnt_o(b_cnt),
    .pd_o(pd), .cp_tri_o(cp_tri), .div_load_o(div_load), .debias_o(debias),
    .ref_osc_en_o(ref_osc_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [18:0] mk_ctl(input logic [1:0] code, input logic [13:0] r,
                                         input logic t, input logic p);
    logic [18:0] w = '0;
    w[1:0] = code; w[15:2] = r; w[16] = t; w[17] = p;
    return w;
  endfunction

  function automatic logic [18:0] mk_div(input logic [5:0] a, input logic [10:0] b);
    return {b, a, 2'b01};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "ref_cnt", int'(ref_cnt), int'(m_ref));
    chk(tag, "a_cnt", int'(a_cnt), int'(m_a));
    chk(tag, "b_cnt", int'(b_cnt), int'(m_b));
    for (int i = 0; i < 2; i++) begin
      chk(tag, $sformatf("pd[%0d]", i), int'(pd[i]), int'(m_st[i] == 2));
      chk(tag, $sformatf("div_load[%0d]", i), int'(div_load[i]), int'(m_st[i] == 2));
      chk(tag, $sformatf("debias[%0d]", i), int'(debias[i]), int'(m_st[i] == 2));
      chk(tag, $sformatf("cp_tri[%0d]", i), int'(cp_tri[i]), int'(m_tri[i] | (m_st[i] != 0)));
    end
    chk(tag, "ref_osc_en", int'(ref_osc_en), int'(!(m_pdb[0] & m_pdb[1])));
  endtask

  task automatic model_loop(input int i, input logic t, input logic p);
    if (!p) m_st[i] = 0;
    else if (m_st[i] == 0) m_st[i] = m_tri[i] ? 2 : 1;
    m_tri[i] = t;
    m_pdb[i] = p;
  endtask

  task automatic model_word(input logic [18:0] w);
    case (w[1:0])
      2'b00: begin m_ref = w[15:2]; model_loop(0, w[16], w[17]); end
      2'b01: begin m_a = w[7:2]; m_b = w[18:8]; end
      2'b10: model_loop(1, w[16], w[17]);
      default: ;
    endcase
  endtask

  task automatic shift_word(input logic [18:0] w);
    for (int k = 18; k >= 0; k--) begin
      @(negedge clk); ser_dat = w[k]; ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic latch_word();
    ser_le = 1'b1;
    repeat (5) @(negedge clk);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [18:0] w);
    shift_word(w);
    latch_word();
    model_word(w);
  endtask

  task automatic strobe(input logic [1:0] s);
    @(negedge clk); cmp_stb = s;
    @(negedge clk); cmp_stb = 2'b00;
    for (int i = 0; i < 2; i++) if (s[i] && m_st[i] == 1) m_st[i] = 2;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ref = '0; m_a = '0; m_b = '0; m_tri = '0; m_pdb = '0;
    m_st[0] = 0; m_st[1] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_all("reset");

    // R1: shift without latch changes nothing
    shift_word(mk_ctl(2'b00, 14'h1abc, 1'b1, 1'b1));
    check_all("R1 no-latch");
    latch_word();
    model_word(mk_ctl(2'b00, 14'h1abc, 1'b1, 1'b1));
    check_all("R1 R2 latched");
    send(mk_ctl(2'b00, 14'h0123, 1'b0, 1'b0));
    check_all("R2 R11 clear");

    // R3 divider word
    send(mk_div(6'h2d, 11'h5a3));
    check_all("R3 div");
    // R4 code 11 ignored
    send(19'h7fffc | 19'h3);
    check_all("R4 ignored");

    // R5 sync entry on loop 0
    send(mk_ctl(2'b00, 14'h0777, 1'b0, 1'b1));
    check_all("R5 wait");
    repeat (10) @(negedge clk);
    check_all("R5 still waiting");
    strobe(2'b10);
    check_all("R5 other strobe");
    strobe(2'b01);
    check_all("R5 R8 down");
    // R10 latches active while down
    send(mk_div(6'h11, 11'h123));
    check_all("R10 div while down");
    send(mk_ctl(2'b00, 14'h0042, 1'b0, 1'b0));
    check_all("R11 resume from down");

    // R11 cancel from wait
    send(mk_ctl(2'b00, 14'h0042, 1'b0, 1'b1));
    check_all("R5 wait again");
    send(mk_ctl(2'b00, 14'h0043, 1'b1, 1'b0));
    check_all("R11 cancel wait");
    // R6 async entry (three-state already set)
    send(mk_ctl(2'b00, 14'h0044, 1'b1, 1'b1));
    check_all("R6 async down");

    // R7 loop 1 both modes, R9 both down
    send(mk_ctl(2'b10, 14'h0, 1'b0, 1'b1));
    check_all("R7 R9 loop1 wait");
    strobe(2'b10);
    check_all("R7 R9 loop1 down");
    send(mk_ctl(2'b10, 14'h0, 1'b1, 1'b0));
    check_all("R9 R11 loop1 up");
    send(mk_ctl(2'b10, 14'h0, 1'b1, 1'b1));
    check_all("R7 loop1 async");
    send(mk_ctl(2'b00, 14'h0, 1'b0, 1'b0));
    check_all("R9 loop0 up");

    // random phase
    for (int n = 0; n < 60; n++) begin
      logic [18:0] w;
      w = 19'($urandom);
      if (($urandom % 4) != 0) w[17] = ($urandom % 3) != 0;
      send(w);
      check_all("R1 R5 R6 R7 R10 R11 random word");
      if (($urandom % 3) == 0) begin
        strobe(2'($urandom));
        check_all("R5 R7 random strobe");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule